// File: doc/BRIEF.md
# Trailing bit manipulation unit

This unit builds masks around the lowest set bit or the lowest clear bit of an operand. Each operation takes the operand, its complement, and its value plus or minus one, and joins two of these with a single AND, OR or XOR. There are nine such fixed compositions. The unit can fill, isolate, or mark with a mask the region below the first one bit or the first zero bit.

Each operation works at 64 bits or at 32 bits, chosen per request. The result and three status flags appear in a register one cycle after a valid request. The flags report:

- a zero result;
- a carry for the degenerate operand, which is all zeros for the set-bit group or all ones for the clear-bit group;
- an unsupported operation code.

Top module: `trailing_bit_unit`

## Requirements
- R1: Set-bit group. Op code 0 gives src OR (src-1). Op code 1 gives (NOT src) OR (src-1). Op code 2 gives (NOT src) AND (src-1).
- R2: Op code 2 sets every bit below the lowest one bit of the operand and clears all other bits, including that lowest one bit. For 0x0040201008040200 it gives 0x00000000000001FF.
- R3: Clear-bit group. Op 3 gives src AND (src+1), op 4 gives src OR NOT(src+1), and op 5 gives (NOT src) AND (src+1). Op 6 gives src XOR (src+1), op 7 gives src OR (src+1), and op 8 gives (NOT src) OR (src+1).
- R4: When in_narrow is 1, only bits 31:0 of the source are used. The increment and decrement wrap at 32 bits, result bits 63:32 are zero, and source bits 63:32 have no effect on the result or flags.
- R5: Arithmetic is modular. A zero operand makes src-1 all ones, and an all-ones operand makes src+1 zero, each within the selected width.
- R6: out_zero is 1 exactly when out_result is zero.
- R7: out_carry is 1 in two cases: for ops 0 to 2 when the operand within the selected width is zero, and for ops 3 to 8 when it is all ones. Otherwise it is 0.
- R8: Op codes 9 to 15 give a zero result with out_illegal 1, out_carry 0 and out_zero 1. Legal codes give out_illegal 0.
- R9: The result and flags of a request accepted with in_valid on a rising edge appear after that edge, with out_valid 1 for exactly one cycle. Back-to-back requests give back-to-back results, and out_valid is 0 after a cycle with no request.
- R10: A synchronous active-high rst clears out_valid, even while in_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_src | input | 64 | Source operand |
| in_op | input | 4 | Operation select, codes 0 to 8 |
| in_narrow | input | 1 | 1 selects 32-bit mode, 0 selects 64-bit mode |
| out_valid | output | 1 | Result registered this cycle |
| out_result | output | 64 | Result word |
| out_zero | output | 1 | Result is zero |
| out_carry | output | 1 | Degenerate operand for the selected group |
| out_illegal | output | 1 | Unsupported operation code |

## Verification
The shape checks assume that out_result is only meaningful while out_valid is high. They therefore qualify every data property with out_valid, because the result register keeps its old contents between requests. They also assume that in_valid and in_op are known on every clock edge outside reset. The bench keeps to this by driving every input from its tasks on the falling edge only and parking in_valid low between scenarios. The stimulus includes illegal codes and 32-bit requests with junk in the upper half, so that the illegal and narrow checks meet the inputs they guard.

// File: rtl/trailing_bit_unit.sv
module trailing_bit_unit #(
  parameter int DATA_W = 64,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_src,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_narrow,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_carry,
  output logic              out_illegal
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [OP_W-1:0]   SET_LAST = OP_W'(2);
  localparam logic [OP_W-1:0]   OP_LAST  = OP_W'(8);
  localparam logic [OP_W-1:0]   OP_TZM   = OP_W'(2);
  localparam logic [OP_W-1:0]   OP_ISOC  = OP_W'(5);
  localparam logic [OP_W-1:0]   OP_CMSK  = OP_W'(6);

  wire [DATA_W-1:0] width_mask = in_narrow ? LOW_MASK : ALL_ONES;
  wire [DATA_W-1:0] opnd       = in_src & width_mask;
  wire [DATA_W-1:0] opnd_n     = ~opnd;
  wire [DATA_W-1:0] opnd_dec   = (opnd - ONE) & width_mask;
  wire [DATA_W-1:0] opnd_inc   = (opnd + ONE) & width_mask;
  wire              op_legal   = in_op <= OP_LAST;
  wire              set_group  = in_op <= SET_LAST;
  wire              degenerate = set_group ? (opnd == '0) : (opnd == width_mask);

  logic [DATA_W-1:0] raw;
  always_comb begin
    case (in_op)
      OP_W'(0): raw = opnd | opnd_dec;
      OP_W'(1): raw = opnd_n | opnd_dec;
      OP_W'(2): raw = opnd_n & opnd_dec;
      OP_W'(3): raw = opnd & opnd_inc;
      OP_W'(4): raw = opnd | ~opnd_inc;
      OP_W'(5): raw = opnd_n & opnd_inc;
      OP_W'(6): raw = opnd ^ opnd_inc;
      OP_W'(7): raw = opnd | opnd_inc;
      OP_W'(8): raw = opnd_n | opnd_inc;
      default:  raw = '0;
    endcase
  end

  wire [DATA_W-1:0] next_result = raw & width_mask;

  logic [OP_W-1:0] held_op;
  logic            held_narrow;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_result  <= next_result;
      out_zero    <= next_result == '0;
      out_carry   <= op_legal && degenerate;
      out_illegal <= !op_legal;
      held_op     <= in_op;
      held_narrow <= in_narrow;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> !out_valid);
  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && held_narrow) |-> (out_result[DATA_W-1:HALF_W] == '0));
  assert_tzmask_shape_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && held_op == OP_TZM) |-> $onehot0(out_result + ONE));
  assert_clrmask_shape_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && held_op == OP_CMSK) |-> $onehot0(out_result + ONE));
  assert_isolate_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && held_op == OP_ISOC) |-> $onehot0(out_result));
  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_zero == (out_result == '0)));
  assert_illegal_code_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_illegal == (held_op > OP_LAST)));
  assert_illegal_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0 && !out_carry));

endmodule

// File: tb/test_trailing_bit_unit.sv
module test_trailing_bit_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_src = '0;
  logic [3:0]  in_op = '0;
  logic        in_narrow = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_zero, out_carry, out_illegal;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  trailing_bit_unit i_trailing_bit_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_op(in_op),
    .in_narrow(in_narrow), .out_valid(out_valid), .out_result(out_result),
    .out_zero(out_zero), .out_carry(out_carry), .out_illegal(out_illegal));

  function automatic logic [63:0] ref_res(logic [63:0] s, logic [3:0] op, logic nar);
    logic [63:0] m, a, d, i, r;
    m = nar ? 64'h0000_0000_FFFF_FFFF : '1;
    a = s & m;
    d = (a - 64'd1) & m;
    i = (a + 64'd1) & m;
    case (op)
      4'd0: r = a | d;
      4'd1: r = ~a | d;
      4'd2: r = ~a & d;
      4'd3: r = a & i;
      4'd4: r = a | ~i;
      4'd5: r = ~a & i;
      4'd6: r = a ^ i;
      4'd7: r = a | i;
      4'd8: r = ~a | i;
      default: r = '0;
    endcase
    return r & m;
  endfunction

  function automatic logic ref_carry(logic [63:0] s, logic [3:0] op, logic nar);
    logic [63:0] m, a;
    m = nar ? 64'h0000_0000_FFFF_FFFF : '1;
    a = s & m;
    if (op <= 4'd2) return a == '0;
    if (op <= 4'd8) return a == m;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] s, logic [3:0] op, logic nar);
    in_valid = 1'b1; in_src = s; in_op = op; in_narrow = nar;
  endtask

  task automatic check_all(string req, logic [63:0] s, logic [3:0] op, logic nar);
    logic [63:0] e;
    e = ref_res(s, op, nar);
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " result"}, out_result, e);
    chk({req, " zero R6"}, 64'(out_zero), 64'(e == '0));
    chk({req, " carry R7"}, 64'(out_carry), 64'(ref_carry(s, op, nar)));
    chk({req, " illegal R8"}, 64'(out_illegal), 64'(op > 4'd8));
  endtask

  task automatic apply(string req, logic [63:0] s, logic [3:0] op, logic nar, logic [63:0] exp);
    @(negedge clk); drive(s, op, nar);
    @(negedge clk); in_valid = 1'b0;
    check_all(req, s, op, nar);
    chk({req, " known"}, out_result, exp);
  endtask

  task automatic t_reset;
    in_valid = 1'b1; in_src = '1; in_op = 4'd0;
    repeat (3) @(negedge clk);
    chk("R10 valid held low in reset", 64'(out_valid), 64'd0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk("R9 no valid when idle", 64'(out_valid), 64'd0);
  endtask

  task automatic t_set_group;
    apply("R1 fill lowest set", 64'h0040201008040200, 4'd0, 1'b0, 64'h00402010080403FF);
    apply("R1 isolate complement", 64'h0040201008040200, 4'd1, 1'b0, 64'hFFFFFFFFFFFFFDFF);
    apply("R2 trailing zero mask", 64'h0040201008040200, 4'd2, 1'b0, 64'h00000000000001FF);
    apply("R2 tzmask bit 63", 64'h8000000000000000, 4'd2, 1'b0, 64'h7FFFFFFFFFFFFFFF);
    apply("R2 tzmask bit 0", 64'h0000000000000F01, 4'd2, 1'b0, 64'h0);
  endtask

  task automatic t_clear_group;
    logic [63:0] s;
    s = 64'h80C0E0F0F8FCFEFF;
    apply("R3 fill lowest clear", s, 4'd3, 1'b0, 64'h80C0E0F0F8FCFE00);
    apply("R3 isolate clear", s, 4'd4, 1'b0, 64'hFFFFFFFFFFFFFEFF);
    apply("R3 isolate clear complement", s, 4'd5, 1'b0, 64'h0000000000000100);
    apply("R3 clear mask", s, 4'd6, 1'b0, 64'h00000000000001FF);
    apply("R3 set lowest clear", s, 4'd7, 1'b0, 64'h80C0E0F0F8FCFFFF);
    apply("R3 inverse trailing ones", s, 4'd8, 1'b0, 64'hFFFFFFFFFFFFFF00);
  endtask

  task automatic t_corners;
    apply("R5 R7 zero fill", 64'h0, 4'd0, 1'b0, '1);
    apply("R5 R7 zero tzmask", 64'h0, 4'd2, 1'b0, '1);
    apply("R5 R7 zero isocomp", 64'h0, 4'd1, 1'b0, '1);
    apply("R5 R7 ones clear fill", '1, 4'd3, 1'b0, 64'h0);
    apply("R5 R7 ones clear mask", '1, 4'd6, 1'b0, '1);
    apply("R5 R7 ones isocomp", '1, 4'd5, 1'b0, 64'h0);
    apply("R7 zero on clear group", 64'h0, 4'd7, 1'b0, 64'h1);
    apply("R7 ones on set group", '1, 4'd0, 1'b0, '1);
  endtask

  task automatic t_narrow;
    apply("R4 narrow zero low", 64'hDEADBEEF00000000, 4'd0, 1'b1, 64'h00000000FFFFFFFF);
    apply("R4 narrow ones low", 64'h12345678FFFFFFFF, 4'd7, 1'b1, 64'h00000000FFFFFFFF);
    apply("R4 narrow ones mask", 64'hA5A5A5A5FFFFFFFF, 4'd6, 1'b1, 64'h00000000FFFFFFFF);
    apply("R4 narrow isolate", 64'hFFFFFFFF0000FFFF, 4'd4, 1'b1, 64'h00000000FFFEFFFF);
    apply("R4 narrow tzmask", 64'hFFFFFFFF00001000, 4'd2, 1'b1, 64'h0000000000000FFF);
    apply("R4 wide contrast", 64'h12345678FFFFFFFF, 4'd7, 1'b0, 64'h12345679FFFFFFFF);
  endtask

  task automatic t_illegal;
    for (int c = 9; c < 16; c++)
      apply("R8 illegal code", 64'h0123456789ABCDEF, 4'(c), c[0], 64'h0);
  endtask

  task automatic t_stream;
    @(negedge clk); drive(64'h0000000000000030, 4'd0, 1'b0);
    @(negedge clk); drive(64'h0000000000000007, 4'd8, 1'b0);
    check_all("R9 back to back first", 64'h30, 4'd0, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    check_all("R9 back to back second", 64'h7, 4'd8, 1'b0);
    @(negedge clk);
    chk("R9 single cycle valid", 64'(out_valid), 64'd0);
    @(negedge clk); drive(64'h5, 4'd1, 1'b0); rst = 1'b1;
    @(negedge clk); in_valid = 1'b0; rst = 1'b0;
    chk("R10 reset beats request", 64'(out_valid), 64'd0);
  endtask

  task automatic t_sweep;
    logic [63:0] s;
    s = 64'h9E3779B97F4A7C15;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); drive(s, 4'(k % 9), k[1]);
      @(negedge clk); in_valid = 1'b0;
      check_all("R1 R3 sweep", s, 4'(k % 9), k[1]);
      s = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]} << (k % 3);
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_set_group();
    t_clear_group();
    t_corners();
    t_narrow();
    t_illegal();
    t_stream();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule